// File: doc/BRIEF.md
# Interrupt Steering Multiplexer

This block collects a parameterised number of groups of level-sensitive interrupt lines, 64 lines per group, and merges them onto one of several output interrupt channels. Software configures it through a small 32-bit register bank. The bank holds:

- a one-hot channel selector;
- a per-word enable mask;
- per-word software-set bits;
- read-only masked status words;
- a master disable;
- a read-only master-status word.

The lines are packed into 32-bit words with the word order reversed: line k lives in word `2*GROUPS - 1 - k/32` at bit `k % 32`, so word 0 holds the highest-numbered lines. The mask, set and status banks each contain `2*GROUPS` words, so their base offsets move with the `GROUPS` parameter. A host reads the status words to find pending sources, writes mask bits to enable or block lines, and reads the masks back to save and restore them. The status word and the outputs follow the input levels with one register stage of delay.

Top module: `isteer_top`

## Requirements
- R1: After a synchronous active-low reset, the channel selector, every mask word, every set word and the master disable read as zero. Every status word and `irq_out` are also zero.
- R2: A write to mask word n at offset `0x4 + 4n` is read back unchanged at the same offset, and it leaves the other mask words unchanged.
- R3: Input line k is reported in status word `2*GROUPS - 1 - k/32`, at offset `16*GROUPS + 0x4 + 4n`, on bit `k % 32`.
- R4: Each status bit is the input level OR the software-set bit, AND the mask bit, where a mask bit of 1 enables the line. It is registered, so it reflects inputs and registers from the previous clock edge.
- R5: Set word n at offset `8*GROUPS + 0x4 + 4n` reads back as written. It raises the matching status bits while the inputs are low.
- R6: `irq_out[c]` is high exactly when selector bit c at offset `0x0` is set, some status bit is set, and the master disable is clear.
- R7: Writing 1 to bit 0 of the master-disable register at `24*GROUPS + 0x4` drives every `irq_out` low from the next cycle. The status words stay unchanged.
- R8: Master status at `24*GROUPS + 0x8` has bit c set when selector bit c is set and any status bit is set, whatever the master disable holds.
- R9: Reading a status word has no side effect: repeated reads return the same value.
- R10: Reads from unmapped or misaligned offsets return zero. Writes to them, and writes to the status and master-status words, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 64*GROUPS | Level-sensitive interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_out | output | N_CHAN | Output interrupt channels |

## Verification
The steering path is driven with a single high line at the lowest, a middle and the highest line number. This separates a correct reversed word order from a straight one, and a correct bit position from a shifted one. A pattern with the mask cleared only under an active line separates masking from pass-through. A set bit with all inputs low shows that the software path joins the OR. Channel selection is swapped between two one-hot values and then combined with the master disable, which separates per-channel gating from global gating and shows that master status ignores the disable. Writes to read-only, unmapped and misaligned offsets are followed by readback of the words they could have corrupted.

// File: rtl/isteer_pkg.sv
// Package: shared helpers for the interrupt steering multiplexer.
// Assumes 32-bit register words and 64 lines per group.
package isteer_pkg;

    localparam int WORD_W      = 32;
    localparam int LINES_PER_G = 64;

    // First line number held in status/mask word n (words are in reverse order).
    function automatic int line_base(input int groups, input int n);
        return (groups * 2 - 1 - n) * WORD_W;
    endfunction

    // Byte offset of the first mask word.
    function automatic int mask_base(input int groups);
        return (groups * 0) + 4;
    endfunction

    // Byte offset of the first software-set word.
    function automatic int set_base(input int groups);
        return groups * 8 + 4;
    endfunction

    // Byte offset of the first status word.
    function automatic int stat_base(input int groups);
        return groups * 16 + 4;
    endfunction

    // Byte offset of the master-disable register.
    function automatic int mdis_off(input int groups);
        return groups * 24 + 4;
    endfunction

    // Byte offset of the master-status register.
    function automatic int mstat_off(input int groups);
        return groups * 24 + 8;
    endfunction

endpackage

// File: rtl/isteer_regs.sv
// Module: isteer_regs
// Holds the writable registers (selector, masks, set words, master disable)
// and decodes reads across the whole map. Status and master status come in
// from the datapath. Assumes ADDR_W is wide enough to reach the master-status offset.
module isteer_regs
    import isteer_pkg::*;
#(
    parameter int GROUPS = 2,
    parameter int N_CHAN = 4,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [WORD_W-1:0]             reg_wdata,
    input  logic [2*GROUPS-1:0][WORD_W-1:0] stat_q,
    input  logic [N_CHAN-1:0]             mstat,
    output logic [WORD_W-1:0]             reg_rdata,
    output logic [N_CHAN-1:0]             ctrl_q,
    output logic                          mdis_q,
    output logic [2*GROUPS-1:0][WORD_W-1:0] mask_q,
    output logic [2*GROUPS-1:0][WORD_W-1:0] set_q
);

    localparam int NW     = 2 * GROUPS;
    localparam int MASK_B = mask_base(GROUPS);
    localparam int SET_B  = set_base(GROUPS);
    localparam int STAT_B = stat_base(GROUPS);
    localparam int MDIS_A = mdis_off(GROUPS);
    localparam int MST_A  = mstat_off(GROUPS);

    // Register writes; only exact aligned offsets of writable registers match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mdis_q <= 1'b0;
            mask_q <= '0;
            set_q  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == '0)
                ctrl_q <= reg_wdata[N_CHAN-1:0];
            if (reg_addr == ADDR_W'(MDIS_A))
                mdis_q <= reg_wdata[0];
            for (int n = 0; n < NW; n++) begin
                if (reg_addr == ADDR_W'(MASK_B + 4 * n))
                    mask_q[n] <= reg_wdata;
                if (reg_addr == ADDR_W'(SET_B + 4 * n))
                    set_q[n] <= reg_wdata;
            end
        end
    end

    // Read decode; anything not matched returns zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0)
            reg_rdata = {{(WORD_W-N_CHAN){1'b0}}, ctrl_q};
        if (reg_addr == ADDR_W'(MDIS_A))
            reg_rdata = {{(WORD_W-1){1'b0}}, mdis_q};
        if (reg_addr == ADDR_W'(MST_A))
            reg_rdata = {{(WORD_W-N_CHAN){1'b0}}, mstat};
        for (int n = 0; n < NW; n++) begin
            if (reg_addr == ADDR_W'(MASK_B + 4 * n)) reg_rdata = mask_q[n];
            if (reg_addr == ADDR_W'(SET_B  + 4 * n)) reg_rdata = set_q[n];
            if (reg_addr == ADDR_W'(STAT_B + 4 * n)) reg_rdata = stat_q[n];
        end
    end

endmodule

// File: rtl/isteer_status.sv
// Module: isteer_status
// Builds the registered masked status words from the input levels and the
// software-set words, and flags whether any status bit is set. Assumes the
// inputs are already synchronous to clk.
module isteer_status
    import isteer_pkg::*;
#(
    parameter int GROUPS = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [LINES_PER_G*GROUPS-1:0]   irq_in,
    input  logic [2*GROUPS-1:0][WORD_W-1:0] mask_q,
    input  logic [2*GROUPS-1:0][WORD_W-1:0] set_q,
    output logic [2*GROUPS-1:0][WORD_W-1:0] stat_q,
    output logic                            pend_any
);

    localparam int NW = 2 * GROUPS;

    for (genvar n = 0; n < NW; n++) begin : g_word
        localparam int BASE = line_base(GROUPS, n);

        // Capture one status word: raw level or set bit, gated by the mask.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[n] <= '0;
            else
                stat_q[n] <= (irq_in[BASE +: WORD_W] | set_q[n]) & mask_q[n];
        end
    end

    // Reduce all status words to a single pending flag.
    always_comb pend_any = |stat_q;

endmodule

// File: rtl/isteer_route.sv
// Module: isteer_route
// Steers the pending flag onto the channels named by the selector and forms
// the master-status word. Assumes the selector is normally one-hot.
module isteer_route #(
    parameter int N_CHAN = 4
) (
    input  logic              pend_any,
    input  logic              mdis_q,
    input  logic [N_CHAN-1:0] ctrl_q,
    output logic [N_CHAN-1:0] irq_out,
    output logic [N_CHAN-1:0] mstat
);

    // Per-channel gating of the output and of the master status.
    always_comb begin
        for (int c = 0; c < N_CHAN; c++) begin
            mstat[c]   = ctrl_q[c] & pend_any;
            irq_out[c] = ctrl_q[c] & pend_any & ~mdis_q;
        end
    end

endmodule

// File: rtl/isteer_top.sv
// Module: isteer_top
// Interrupt steering multiplexer: GROUPS*64 level inputs, masked and
// merged onto one of N_CHAN outputs, with a 32-bit register bank.
// Assumes a single clock domain and that ADDR_W reaches 24*GROUPS+8.
module isteer_top
    import isteer_pkg::*;
#(
    parameter int GROUPS = 2,
    parameter int N_CHAN = 4,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LINES_PER_G*GROUPS-1:0] irq_in,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [WORD_W-1:0]             reg_wdata,
    output logic [WORD_W-1:0]             reg_rdata,
    output logic [N_CHAN-1:0]             irq_out
);

    localparam int NW = 2 * GROUPS;

    logic [N_CHAN-1:0]             ctrl_q;
    logic                          mdis_q;
    logic [NW-1:0][WORD_W-1:0]     mask_q;
    logic [NW-1:0][WORD_W-1:0]     set_q;
    logic [NW-1:0][WORD_W-1:0]     stat_q;
    logic [N_CHAN-1:0]             mstat;
    logic                          pend_any;

    isteer_regs #(.GROUPS(GROUPS), .N_CHAN(N_CHAN), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .stat_q(stat_q), .mstat(mstat),
        .reg_rdata(reg_rdata), .ctrl_q(ctrl_q), .mdis_q(mdis_q),
        .mask_q(mask_q), .set_q(set_q)
    );

    isteer_status #(.GROUPS(GROUPS)) u_status (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_q(mask_q),
        .set_q(set_q), .stat_q(stat_q), .pend_any(pend_any)
    );

    isteer_route #(.N_CHAN(N_CHAN)) u_route (
        .pend_any(pend_any), .mdis_q(mdis_q), .ctrl_q(ctrl_q),
        .irq_out(irq_out), .mstat(mstat)
    );

endmodule

// File: rtl/isteer_chk.sv
// Module: isteer_chk
// Property checker for isteer_top, attached by bind below.
module isteer_chk
    import isteer_pkg::*;
#(
    parameter int GROUPS = 2,
    parameter int N_CHAN = 4,
    parameter int ADDR_W = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            reg_wr,
    input logic [ADDR_W-1:0]               reg_addr,
    input logic [WORD_W-1:0]               reg_wdata,
    input logic [WORD_W-1:0]               reg_rdata,
    input logic [N_CHAN-1:0]               irq_out,
    input logic [N_CHAN-1:0]               ctrl_q,
    input logic [N_CHAN-1:0]               mstat,
    input logic [2*GROUPS-1:0][WORD_W-1:0] mask_q,
    input logic [2*GROUPS-1:0][WORD_W-1:0] stat_q
);

    localparam int MDIS_A = mdis_off(GROUPS);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_out == '0)); // R1

    AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~$past(mask_q)) == '0); // R4

    AST_OUT_IN_SELECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~ctrl_q) == '0); // R6

    AST_OUT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> (stat_q != '0)); // R6

    AST_DISABLE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(MDIS_A) && reg_wdata[0]) |=> (irq_out == '0)); // R7

    AST_MSTAT_COVERS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~mstat) == '0); // R8

    AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0)); // R10

endmodule

bind isteer_top isteer_chk #(.GROUPS(GROUPS), .N_CHAN(N_CHAN), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
    .ctrl_q(ctrl_q), .mstat(mstat), .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/isteer_top_tb.sv
`timescale 1ns/1ps
module isteer_top_tb;

    localparam int G  = 2;
    localparam int NC = 4;
    localparam int AW = 8;
    localparam int NW = 2 * G;
    // Offsets for G = 2
    localparam logic [AW-1:0] A_CTRL  = 8'h00;
    localparam logic [AW-1:0] A_MASK  = 8'h04;
    localparam logic [AW-1:0] A_SET   = 8'h14;
    localparam logic [AW-1:0] A_STAT  = 8'h24;
    localparam logic [AW-1:0] A_MDIS  = 8'h34;
    localparam logic [AW-1:0] A_MSTAT = 8'h38;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [64*G-1:0] irq_in = '0;
    logic            reg_wr = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NC-1:0]   irq_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    isteer_top #(.GROUPS(G), .N_CHAN(NC), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_all();
        irq_in = '0;
        wr(A_CTRL, 32'h0); wr(A_MDIS, 32'h0);
        for (int n = 0; n < NW; n++) begin
            wr(A_MASK + AW'(4*n), 32'h0);
            wr(A_SET  + AW'(4*n), 32'h0);
        end
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_MDIS, d); chk("R1 mdis", d, 0);
        for (int n = 0; n < NW; n++) begin
            rd(A_MASK + AW'(4*n), d); chk("R1 mask", d, 0);
            rd(A_SET  + AW'(4*n), d); chk("R1 set", d, 0);
            rd(A_STAT + AW'(4*n), d); chk("R1 stat", d, 0);
        end
        chk("R1 irq_out", 32'(irq_out), 0);
    endtask

    task automatic t_mask_rb();
        logic [31:0] d;
        wr(A_MASK + 4, 32'hA5A5_0F0F);
        rd(A_MASK + 4, d); chk("R2 mask1 readback", d, 32'hA5A5_0F0F);
        rd(A_MASK, d);     chk("R2 mask0 untouched", d, 0);
        rd(A_MASK + 8, d); chk("R2 mask2 untouched", d, 0);
        clear_all();
    endtask

    task automatic t_mapping();
        logic [31:0] d;
        for (int n = 0; n < NW; n++) wr(A_MASK + AW'(4*n), 32'hFFFF_FFFF);
        irq_in = '0; irq_in[0] = 1'b1; settle();
        rd(A_STAT + 12, d); chk("R3 line0 word3", d, 32'h1);
        rd(A_STAT, d);      chk("R3 line0 not word0", d, 0);
        irq_in = '0; irq_in[37] = 1'b1; settle();
        rd(A_STAT + 8, d);  chk("R3 line37 word2", d, 32'h20);
        irq_in = '0; irq_in[127] = 1'b1; settle();
        rd(A_STAT, d);      chk("R3 line127 word0", d, 32'h8000_0000);
        rd(A_STAT + 12, d); chk("R3 line127 not word3", d, 0);
        clear_all();
    endtask

    task automatic t_mask_block();
        logic [31:0] d;
        wr(A_MASK + 12, 32'hFFFF_FFFE);
        irq_in = '0; irq_in[0] = 1'b1; settle();
        rd(A_STAT + 12, d); chk("R4 masked line0", d, 0);
        irq_in[1] = 1'b1; settle();
        rd(A_STAT + 12, d); chk("R4 enabled line1", d, 32'h2);
        irq_in = '0; settle();
        rd(A_STAT + 12, d); chk("R4 level drop", d, 0);
        clear_all();
    endtask

    task automatic t_swset();
        logic [31:0] d;
        wr(A_MASK + 4, 32'hFFFF_FFFF);
        wr(A_SET + 4, 32'h8000_0001); settle();
        rd(A_SET + 4, d);  chk("R5 set readback", d, 32'h8000_0001);
        rd(A_STAT + 4, d); chk("R5 set drives status", d, 32'h8000_0001);
        wr(A_MASK + 4, 32'h0000_0001); settle();
        rd(A_STAT + 4, d); chk("R5 set under mask", d, 32'h1);
        clear_all();
    endtask

    task automatic t_steer_disable();
        logic [31:0] d;
        wr(A_CTRL, 32'h4); settle();
        chk("R6 no pending", 32'(irq_out), 0);
        wr(A_MASK, 32'h0000_0010);
        irq_in[100] = 1'b1; settle();
        chk("R6 channel2", 32'(irq_out), 32'h4);
        wr(A_CTRL, 32'h1); settle();
        chk("R6 channel0", 32'(irq_out), 32'h1);
        rd(A_MSTAT, d); chk("R8 mstat enabled", d, 32'h1);
        wr(A_MDIS, 32'h1); settle();
        chk("R7 disabled out", 32'(irq_out), 0);
        rd(A_STAT, d);  chk("R7 status kept", d, 32'h10);
        rd(A_MSTAT, d); chk("R8 mstat ignores disable", d, 32'h1);
        wr(A_MDIS, 32'h0); settle();
        chk("R7 re-enabled", 32'(irq_out), 32'h1);
        clear_all();
    endtask

    task automatic t_noside();
        logic [31:0] d1, d2;
        wr(A_MASK + 8, 32'hFFFF_FFFF);
        irq_in[40] = 1'b1; settle();
        rd(A_STAT + 8, d1);
        rd(A_STAT + 8, d2);
        chk("R9 first read", d1, 32'h100);
        chk("R9 repeat read", d2, 32'h100);
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(8'h3C, d); chk("R10 unmapped read", d, 0);
        rd(8'h05, d); chk("R10 misaligned read", d, 0);
        wr(8'h05, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_MSTAT, 32'hF);
        settle();
        rd(A_MASK, d);  chk("R10 mask0 after stray writes", d, 0);
        rd(A_MASK + 4, d); chk("R10 mask1 after stray writes", d, 0);
        rd(A_STAT, d);  chk("R10 status not writable", d, 0);
        rd(A_MSTAT, d); chk("R10 mstat not writable", d, 0);
        rd(A_CTRL, d);  chk("R10 ctrl untouched", d, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_rb();
        t_mapping();
        t_mask_block();
        t_swset();
        t_steer_disable();
        t_noside();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule